// File: doc/BRIEF.md
# Dithered Odd-Sample Requantizer

This block takes a signed difference code in the range -32 to +32 (65 levels) and reduces it to a signed code in the range -16 to +16 (33 levels). It does this by adding a switching term and halving the result. Even codes halve exactly. An odd code is first moved to its upper or lower even neighbour. The direction of that move comes from a small first-order loop that is driven by a one-bit random dither, so the rounding error has a highpass spectrum and does not depend on the input.

The loop remembers the sum of every switching term it has produced. That sum is always -1, 0 or +1. A positive sum forces the next odd code down. A negative sum forces it up. A zero sum lets the dither bit pick the direction. The loop advances only on valid odd samples. The dither source sits outside the block. Each valid sample appears at the output exactly one clock after it is presented.

Top module: `rq_requant`

## Requirements
- R1: A valid even input x produces the output x/2, so the switching term is zero.
- R2: A valid odd input x produces either (x+1)/2 or (x-1)/2, so the switching term is +1 or -1.
- R3: The sum of the switching terms since reset always stays in {-1, 0, +1}. When that sum is +1 the next odd sample uses -1, and when it is -1 the next odd sample uses +1.
- R4: When the sum is 0, an odd sample with dither_bit = 1 uses +1 and an odd sample with dither_bit = 0 uses -1.
- R5: Even samples, and cycles with in_valid low, leave the loop state unchanged, whatever the dither and the data are.
- R6: The output stays within -16..+16 for every input in -32..+32. An input of +31 gives 15 or 16, -31 gives -15 or -16, +32 gives 16 and -32 gives -16.
- R7: out_valid is in_valid delayed by one clock. out_value changes only one clock after a valid input and holds its value at every other time.
- R8: Reset (rst_n low) drives out_valid to 0 and out_value to 0, and returns the switching sum to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_value as a sample in this cycle |
| in_value | input | 7 | Signed two's-complement difference code, -32..+32 |
| dither_bit | input | 1 | Random bit (0 or 1) that breaks ties when the sum is 0 |
| out_valid | output | 1 | Marks out_value as a new result |
| out_value | output | 6 | Signed two's-complement requantized code, -16..+16 |

## Verification
The assertions assume that in_value stays within -32..+32 whenever in_valid is high. They also assume that in_value and dither_bit are known values in every cycle after reset. The stimulus draws values only from that range. It covers the edge codes ±31 and ±32 on purpose. It holds all inputs at defined values even when in_valid is low, and it still sends odd codes on idle cycles to show that they are ignored. The dither comes from a linear feedback shift register in the bench, so tied decisions take both directions.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Switching term in sign/magnitude form: mag=0 means zero, else +/-1.
  typedef struct packed {
    logic neg;
    logic mag;
  } rq_sw_t;

endpackage

// File: rtl/rq_switch_loop.sv
module rq_switch_loop
  import rq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   odd,
  input  logic   dither,
  output rq_sw_t sw,
  output logic   st_mag,
  output logic   st_neg
);

  logic upd_en;
  logic mag_d;
  logic neg_d;

  // Running sum is +1, -1 or 0 (st_mag=0). A nonzero sum forces the
  // opposite sign; a zero sum takes its sign from the dither.
  always_comb begin
    sw.mag = odd;
    sw.neg = odd & (st_mag ? ~st_neg : ~dither);
    upd_en = in_valid & odd;
    mag_d  = ~st_mag;
    neg_d  = st_mag ? 1'b0 : sw.neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mag <= 1'b0;
      st_neg <= 1'b0;
    end else if (upd_en) begin
      st_mag <= mag_d;
      st_neg <= neg_d;
    end
  end

endmodule

// File: rtl/rq_halver.sv
module rq_halver
  import rq_pkg::*;
#(
  parameter int IN_W  = 7,
  parameter int OUT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_value,
  input  rq_sw_t                  sw,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_value
);

  localparam int SUM_W = IN_W + 1;

  logic signed [SUM_W-1:0] x_ext;
  logic signed [SUM_W-1:0] s_ext;
  logic signed [SUM_W-1:0] sum_c;
  logic signed [OUT_W-1:0] half_c;
  logic                    val_d;
  logic signed [OUT_W-1:0] out_d;

  always_comb begin
    x_ext = {in_value[IN_W-1], in_value};
    unique case ({sw.mag, sw.neg})
      2'b10:   s_ext = {{(SUM_W-1){1'b0}}, 1'b1};
      2'b11:   s_ext = {SUM_W{1'b1}};
      default: s_ext = '0;
    endcase
    sum_c  = x_ext + s_ext;
    // sum_c is even by construction; dropping bit 0 is an exact halving.
    half_c = sum_c[OUT_W:1];
    val_d  = in_valid;
    out_d  = in_valid ? half_c : out_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= val_d;
      out_value <= out_d;
    end
  end

endmodule

// File: rtl/rq_requant.sv
module rq_requant
  import rq_pkg::*;
#(
  parameter  int OUT_MAG = 16,
  localparam int IN_W    = $clog2(2*OUT_MAG + 1) + 1,
  localparam int OUT_W   = $clog2(OUT_MAG + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_value,
  input  logic                    dither_bit,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_value
);

  rq_sw_t sw;
  logic   loop_mag;
  logic   loop_neg;

  rq_switch_loop u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .odd      (in_value[0]),
    .dither   (dither_bit),
    .sw       (sw),
    .st_mag   (loop_mag),
    .st_neg   (loop_neg)
  );

  rq_halver #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
  ) u_half (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_value  (in_value),
    .sw        (sw),
    .out_valid (out_valid),
    .out_value (out_value)
  );

endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
  parameter int OUT_MAG = 16,
  parameter int IN_W    = 7,
  parameter int OUT_W   = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_value,
  input logic                    dither_bit,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_value,
  input logic                    loop_mag,
  input logic                    loop_neg
);

  logic signed [IN_W-1:0] pend_x;
  logic                   pend_d;
  int                     chk_sum;
  int                     obs_s;

  always_comb obs_s = 2 * int'(out_value) - int'(pend_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_x  <= '0;
      pend_d  <= 1'b0;
      chk_sum <= 0;
    end else begin
      if (in_valid) begin
        pend_x <= in_value;
        pend_d <= dither_bit;
      end
      if (out_valid && pend_x[0]) chk_sum <= chk_sum + obs_s;
    end
  end

  AST_EVEN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pend_x[0]) |-> (obs_s == 0));  // R1
  AST_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pend_x[0]) |-> (obs_s == 1 || obs_s == -1));  // R2
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_sum >= -1 && chk_sum <= 1));  // R3
  AST_FORCED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pend_x[0] && chk_sum != 0) |-> (obs_s == -chk_sum));  // R3
  AST_TIE_DITHER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pend_x[0] && chk_sum == 0) |-> (obs_s == (pend_d ? 1 : -1)));  // R4
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_value[0]) |=> $stable({loop_mag, loop_neg}));  // R5
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_value) >= -OUT_MAG && int'(out_value) <= OUT_MAG));  // R6
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_value)));  // R7
  AST_ZERO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_mag |-> !loop_neg);  // R8

endmodule

bind rq_requant rq_requant_chk #(
  .OUT_MAG (OUT_MAG),
  .IN_W    (IN_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_value   (in_value),
  .dither_bit (dither_bit),
  .out_valid  (out_valid),
  .out_value  (out_value),
  .loop_mag   (loop_mag),
  .loop_neg   (loop_neg)
);

// File: tb/rq_requant_tb.sv
module rq_requant_tb;

  localparam int OUT_MAG = 16;
  localparam int IN_W    = 7;
  localparam int OUT_W   = 6;

  logic                    clk        = 1'b0;
  logic                    rst_n      = 1'b0;
  logic                    in_valid   = 1'b0;
  logic signed [IN_W-1:0]  in_value   = '0;
  logic                    dither_bit = 1'b0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_value;

  always #5 clk = ~clk;

  rq_requant #(.OUT_MAG(OUT_MAG)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_value   (in_value),
    .dither_bit (dither_bit),
    .out_valid  (out_valid),
    .out_value  (out_value)
  );

  typedef struct {
    int    x;
    int    expv;
    string tag;
  } item_t;

  item_t       sb_q[$];
  int          m_acc    = 0;
  int          obs_sum  = 0;
  int          last_out = 0;
  int          total    = 0;
  int          bad      = 0;
  bit          done     = 1'b0;
  logic [15:0] lfsr     = 16'hACE1;

  task automatic report(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(input bit v, input int x, input bit d, input string tag);
    @(negedge clk);
    in_valid   = v;
    in_value   = IN_W'(x);
    dither_bit = d;
    if (v) begin
      int    s;
      string t;
      s = 0;
      t = tag;
      if (x % 2 != 0) begin
        if (m_acc > 0) begin
          s = -1;
          if (t == "") t = "R3";
        end else if (m_acc < 0) begin
          s = 1;
          if (t == "") t = "R3";
        end else begin
          s = d ? 1 : -1;
          if (t == "") t = "R4";
        end
        m_acc += s;
      end else if (t == "") begin
        t = "R1";
      end
      sb_q.push_back('{x, (x + s) / 2, t});
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    report(out_valid == 1'b0, "R8", int'(out_valid), 0);
    report(out_value == '0, "R8", int'(out_value), 0);
    sb_q.delete();
    m_acc    = 0;
    obs_sum  = 0;
    last_out = 0;
    rst_n    = 1'b1;
  endtask

  function automatic bit next_dither();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Scoreboard monitor: samples on the falling edge, away from updates.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (sb_q.size() == 0) begin
            report(1'b0, "R7", 1, 0);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            report(int'(out_value) == it.expv, it.tag, int'(out_value), it.expv);
            report(int'(out_value) >= -OUT_MAG && int'(out_value) <= OUT_MAG,
                   "R6", int'(out_value), it.expv);
            if (it.x % 2 != 0) begin
              obs_sum += 2 * int'(out_value) - it.x;
              report(obs_sum >= -1 && obs_sum <= 1, "R3", obs_sum, m_acc);
            end
          end
          last_out = int'(out_value);
        end else begin
          report(int'(out_value) == last_out, "R7", int'(out_value), last_out);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    apply_reset();

    // R1: even codes halve exactly
    drive(1, 0, 0, "R1");
    drive(1, 10, 1, "R1");
    drive(1, -22, 0, "R1");
    // R4 then R3: tie uses dither, next odd goes the other way
    drive(1, 7, 1, "R4");     // +1 -> 4, sum +1
    drive(1, 7, 1, "R3");     // -1 -> 3, sum 0
    drive(1, -5, 0, "R4");    // -1 -> -3, sum -1
    drive(1, -5, 0, "R3");    // +1 -> -2, sum 0
    // R5: idle odd codes and even samples do not move the loop
    drive(1, 9, 0, "R2");     // -1 -> 4, sum -1
    drive(0, 11, 1, "");
    drive(0, -3, 0, "");
    drive(1, 4, 1, "R5");
    drive(1, -2, 0, "R5");
    drive(1, 9, 0, "R5");     // sum -1 forces +1 -> 5
    // R6: range edges
    drive(1, 31, 1, "R6");    // sum 0, dither 1 -> 16
    drive(1, 31, 0, "R6");    // forced -1 -> 15
    drive(1, -31, 0, "R6");   // tie, dither 0 -> -16
    drive(1, -31, 1, "R6");   // forced +1 -> -15
    drive(1, 32, 0, "R6");
    drive(1, -32, 1, "R6");
    drive(0, 0, 0, "");
    drive(0, 0, 0, "");

    // R8: reset returns the sum to zero mid-run
    drive(1, 5, 1, "R8");     // sum becomes +1
    drive(0, 0, 0, "");
    drive(0, 0, 0, "");
    apply_reset();
    drive(1, 5, 1, "R8");     // tie again -> 3, not 2

    // Long run of odd samples with pseudo-random dither
    for (int i = 0; i < 64; i++) begin
      int x;
      x = 2 * int'($urandom_range(31)) - 31;
      drive(1, x, next_dither(), "R2");
    end

    // Mixed random traffic with gaps
    for (int i = 0; i < 3000; i++) begin
      bit v;
      int x;
      v = ($urandom_range(3) != 0);
      x = int'($urandom_range(64)) - 32;
      drive(v, x, next_dither(), "");
    end

    drive(0, 0, 0, "");
    drive(0, 0, 0, "");
    @(negedge clk);
    report(sb_q.size() == 0, "R7", sb_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule